// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This block sits between the load/store stage of a 32-bit processor datapath and a byte-addressed data memory whose port is one 32-bit word wide. For a store, it moves the low byte, the low halfword or the whole register value onto the byte lanes that the access address selects, and it raises one write enable per lane. For a load, it takes the addressed byte or halfword out of the memory read word and widens it to 32 bits, either by copying its sign bit or by filling with zeros. Lanes are numbered big-endian: the byte at the lowest address of a word is carried on the most significant eight data bits.

The caller presents an operation code, the two low bits of the byte address, the store value and the memory read word in one cycle. The lane-aligned write word, the byte enables, the widened load value and a misalignment flag appear on registered outputs on the next clock edge. A word access whose address is not a multiple of four, or a halfword access at an odd address, is flagged and suppressed. Address arithmetic, caching and trap handling belong to the surrounding pipeline. The block has no states: its only sequential element is the single output register stage.

Top module: `be_lsu_lanes`

## Requirements
- R1: While `rst_n` is low, all outputs (`mem_wdata_o`, `mem_be_o`, `load_data_o`, `misalign_o`) are zero.
- R2: Outputs are registered. The values on the outputs reflect the inputs sampled at the previous rising clock edge. A change on the inputs between edges does not change the outputs.
- R3: Word store (op 4'h8) at offset 0 gives `mem_be_o` = 1111, and `mem_wdata_o` equals the store value.
- R4: Halfword store (op 4'h9) at offset 0 places store bits [15:0] on [31:16] with `mem_be_o` = 1100. At offset 2 it places them on [15:0] with `mem_be_o` = 0011. Unwritten lanes of `mem_wdata_o` are zero.
- R5: Byte store (op 4'hA) at offset k places store bits [7:0] on data bits [31-8k:24-8k]. Enable bit 3-k is the only enable raised, so offset 0 drives the MSB enable. Unwritten lanes are zero.
- R6: Word load (op 4'h1) at offset 0 returns the memory read word unchanged.
- R7: Signed halfword load (op 4'h2) and signed byte load (op 4'h4) copy the item's top bit into every upper result bit. The item sits at [31:16] for halfword offset 0, at [15:0] for halfword offset 2, and at [31-8k:24-8k] for byte offset k.
- R8: Unsigned halfword load (op 4'h3) and unsigned byte load (op 4'h5) pick the item from the same lanes as R7 and fill the upper result bits with zeros.
- R9: A word access at a nonzero offset, or a halfword access at an odd offset, sets `misalign_o`. In that case `mem_be_o`, `mem_wdata_o` and `load_data_o` are all zero.
- R10: Load operations never raise a byte enable, and they drive `mem_wdata_o` to zero. Op 4'h0 and every undefined code (4'h6, 4'h7, 4'hB to 4'hF) produce all-zero outputs with `misalign_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Access code: 0 idle, 1 word load, 2 signed half load, 3 unsigned half load, 4 signed byte load, 5 unsigned byte load, 8 word store, 9 half store, A byte store |
| addr_lo_i | input | 2 | Low two bits of the byte address (lane offset) |
| store_data_i | input | 32 | Register value to be stored |
| mem_rdata_i | input | 32 | Word read from data memory |
| mem_wdata_o | output | 32 | Lane-aligned write word |
| mem_be_o | output | 4 | Per-lane write enables; bit 3 is offset 0 |
| load_data_o | output | 32 | Extended load result |
| misalign_o | output | 1 | Access was misaligned and has been suppressed |

## Verification
The bench builds the block with its default parameters, four lanes of eight bits. These values make the 32-bit big-endian lane numbering, the pair of halfword positions and all four byte offsets reachable exactly as the requirements state them. Every operation code, including the undefined ones, is driven at every offset against read words whose bytes have mixed sign bits. A long random run then follows, with each cycle compared against a behavioural model. Each new input is also probed before the next clock edge to show that the outputs have not yet followed it.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;

    typedef enum logic [3:0] {
        OP_IDLE = 4'h0,
        OP_LDW  = 4'h1,
        OP_LDH  = 4'h2,
        OP_LDHU = 4'h3,
        OP_LDB  = 4'h4,
        OP_LDBU = 4'h5,
        OP_STW  = 4'h8,
        OP_STH  = 4'h9,
        OP_STB  = 4'hA
    } lsu_op_e;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_HALF = 2'd2,
        SZ_WORD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic      is_load;
        logic      is_store;
        logic      sign_ext;
        acc_size_e size;
    } acc_ctl_t;

endpackage

// File: rtl/lsu_op_decode.sv
module lsu_op_decode
    import be_lsu_pkg::*;
(
    input  logic [3:0] op,
    output acc_ctl_t   ctl
);

    always_comb begin
        ctl = '{is_load: 1'b0, is_store: 1'b0, sign_ext: 1'b0, size: SZ_NONE};
        unique case (op)
            OP_LDW:  ctl = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_WORD};
            OP_LDH:  ctl = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b1, size: SZ_HALF};
            OP_LDHU: ctl = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_HALF};
            OP_LDB:  ctl = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b1, size: SZ_BYTE};
            OP_LDBU: ctl = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_BYTE};
            OP_STW:  ctl = '{is_load: 1'b0, is_store: 1'b1, sign_ext: 1'b0, size: SZ_WORD};
            OP_STH:  ctl = '{is_load: 1'b0, is_store: 1'b1, sign_ext: 1'b0, size: SZ_HALF};
            OP_STB:  ctl = '{is_load: 1'b0, is_store: 1'b1, sign_ext: 1'b0, size: SZ_BYTE};
            default: ctl = '{is_load: 1'b0, is_store: 1'b0, sign_ext: 1'b0, size: SZ_NONE};
        endcase
    end

endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
    import be_lsu_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic             access_en,
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             misalign,
    output logic [LANES-1:0] lane_sel
);

    logic [LANES-1:0] raw_sel;
    logic             active;

    // Lane bit j carries the byte at offset LANES-1-j (big-endian numbering).
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int              K    = LANES - 1 - j;
        localparam logic [OFF_W-1:0] KOFF = OFF_W'(K);
        always_comb begin
            unique case (size)
                SZ_BYTE: raw_sel[j] = (off == KOFF);
                SZ_HALF: raw_sel[j] = (off[OFF_W-1:1] == KOFF[OFF_W-1:1]);
                SZ_WORD: raw_sel[j] = 1'b1;
                default: raw_sel[j] = 1'b0;
            endcase
        end
    end

    always_comb begin
        misalign = 1'b0;
        if (access_en) begin
            if (size == SZ_HALF) misalign = off[0];
            else if (size == SZ_WORD) misalign = (off != '0);
        end
        active   = access_en && !misalign;
        lane_sel = active ? raw_sel : '0;
    end

endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
    import be_lsu_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              store_en,
    input  acc_size_e         size,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] sdata,
    output logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be
);

    for (genvar j = 0; j < LANES; j++) begin : g_pack
        logic [BYTE_W-1:0] src;
        always_comb begin
            unique case (size)
                SZ_WORD: src = sdata[j*BYTE_W +: BYTE_W];
                SZ_HALF: src = sdata[(j % 2)*BYTE_W +: BYTE_W];
                default: src = sdata[BYTE_W-1:0];
            endcase
            be[j]                     = store_en && lane_sel[j];
            wdata[j*BYTE_W +: BYTE_W] = be[j] ? src : '0;
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import be_lsu_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2
) (
    input  logic              load_en,
    input  logic              sign_ext,
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ldata
);

    localparam int HALF_W = 2 * BYTE_W;

    logic [OFF_W-1:0]  half_off;
    logic [DATA_W-1:0] byte_shift;
    logic [DATA_W-1:0] half_shift;
    logic [BYTE_W-1:0] byte_item;
    logic [HALF_W-1:0] half_item;
    logic              byte_fill;
    logic              half_fill;

    always_comb begin
        half_off   = {off[OFF_W-1:1], 1'b0};
        byte_shift = rdata >> (BYTE_W * (LANES - 1 - int'(off)));
        half_shift = rdata >> (BYTE_W * (LANES - 2 - int'(half_off)));
        byte_item  = byte_shift[BYTE_W-1:0];
        half_item  = half_shift[HALF_W-1:0];
        byte_fill  = sign_ext && byte_item[BYTE_W-1];
        half_fill  = sign_ext && half_item[HALF_W-1];

        ldata = '0;
        if (load_en && (lane_sel != '0)) begin
            unique case (size)
                SZ_WORD: ldata = rdata;
                SZ_HALF: ldata = {{(DATA_W-HALF_W){half_fill}}, half_item};
                SZ_BYTE: ldata = {{(DATA_W-BYTE_W){byte_fill}}, byte_item};
                default: ldata = '0;
            endcase
        end
    end

endmodule

// File: rtl/be_lsu_lanes.sv
module be_lsu_lanes
    import be_lsu_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [OFF_W-1:0]  addr_lo_i,
    input  logic [DATA_W-1:0] store_data_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [LANES-1:0]  mem_be_o,
    output logic [DATA_W-1:0] load_data_o,
    output logic              misalign_o
);

    acc_ctl_t          ctl;
    logic              mis_d;
    logic [LANES-1:0]  lane_sel;
    logic [DATA_W-1:0] wdata_d;
    logic [LANES-1:0]  be_d;
    logic [DATA_W-1:0] ldata_d;

    lsu_op_decode u_decode (
        .op  (op_i),
        .ctl (ctl)
    );

    lsu_lane_map #(.LANES(LANES), .OFF_W(OFF_W)) u_lane_map (
        .access_en (ctl.is_load || ctl.is_store),
        .size      (ctl.size),
        .off       (addr_lo_i),
        .misalign  (mis_d),
        .lane_sel  (lane_sel)
    );

    lsu_store_pack #(.LANES(LANES), .BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_store_pack (
        .store_en (ctl.is_store),
        .size     (ctl.size),
        .lane_sel (lane_sel),
        .sdata    (store_data_i),
        .wdata    (wdata_d),
        .be       (be_d)
    );

    lsu_load_extract #(.LANES(LANES), .BYTE_W(BYTE_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_load_extract (
        .load_en  (ctl.is_load),
        .sign_ext (ctl.sign_ext),
        .size     (ctl.size),
        .off      (addr_lo_i),
        .lane_sel (lane_sel),
        .rdata    (mem_rdata_i),
        .ldata    (ldata_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_wdata_o <= '0;
            mem_be_o    <= '0;
            load_data_o <= '0;
            misalign_o  <= 1'b0;
        end else begin
            mem_wdata_o <= wdata_d;
            mem_be_o    <= be_d;
            load_data_o <= ldata_d;
            misalign_o  <= mis_d;
        end
    end

    // R9
    misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> (mem_be_o == '0 && mem_wdata_o == '0 && load_data_o == '0));

    // R5
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mem_be_o) inside {0, 1, 2, LANES});

    // R4
    half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mem_be_o) == 2) |->
            ((mem_be_o & (mem_be_o >> 1) & {(LANES/2){2'b01}}) != '0));

    // R10
    load_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_i) inside {OP_LDW, OP_LDH, OP_LDHU, OP_LDB, OP_LDBU}) |->
            (mem_be_o == '0 && mem_wdata_o == '0));

    // R3
    word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_STW && $past(addr_lo_i) == '0) |->
            (mem_be_o == '1 && mem_wdata_o == $past(store_data_i)));

endmodule

// File: tb/test_be_lsu_lanes.sv
module test_be_lsu_lanes;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'h0;
    logic [1:0]  off = 2'd0;
    logic [31:0] sd = '0;
    logic [31:0] rd = '0;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] load_data;
    logic        misalign;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] e_wd, e_ld;
    logic [3:0]  e_be;
    logic        e_mis;
    string       e_tag;

    always #2 clk = ~clk;

    be_lsu_lanes i_be_lsu_lanes (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op),
        .addr_lo_i    (off),
        .store_data_i (sd),
        .mem_rdata_i  (rd),
        .mem_wdata_o  (mem_wdata),
        .mem_be_o     (mem_be),
        .load_data_o  (load_data),
        .misalign_o   (misalign)
    );

    // Behavioural reference computed from the requirements.
    task automatic model(input logic [3:0] o, input logic [1:0] a,
                         input logic [31:0] s, input logic [31:0] r);
        int unsigned sh;
        logic [15:0] h;
        logic [7:0]  b;
        e_wd = '0; e_be = '0; e_ld = '0; e_mis = 0; e_tag = "R10";
        sh = 24 - 8 * int'(a);
        b  = 8'((r >> sh) & 32'hFF);
        h  = (a[1] == 1'b0) ? r[31:16] : r[15:0];
        case (o)
            4'h1: begin e_tag = "R6"; if (a != 0) e_mis = 1; else e_ld = r; end
            4'h2, 4'h3: begin
                e_tag = (o == 4'h2) ? "R7" : "R8";
                if (a[0]) e_mis = 1;
                else e_ld = (o == 4'h2 && h[15]) ? {16'hFFFF, h} : {16'h0, h};
            end
            4'h4, 4'h5: begin
                e_tag = (o == 4'h4) ? "R7" : "R8";
                e_ld = (o == 4'h4 && b[7]) ? {24'hFFFFFF, b} : {24'h0, b};
            end
            4'h8: begin e_tag = "R3"; if (a != 0) e_mis = 1; else begin e_be = 4'hF; e_wd = s; end end
            4'h9: begin
                e_tag = "R4";
                if (a[0]) e_mis = 1;
                else if (a == 0) begin e_be = 4'b1100; e_wd = {s[15:0], 16'h0}; end
                else begin e_be = 4'b0011; e_wd = {16'h0, s[15:0]}; end
            end
            4'hA: begin
                e_tag = "R5";
                e_be = 4'b1000 >> a;
                e_wd = {24'h0, s[7:0]} << sh;
            end
            default: e_tag = "R10";
        endcase
        if (e_mis) e_tag = "R9";
    endtask

    task automatic compare(input string tag, input logic [31:0] wd, input logic [3:0] be,
                           input logic [31:0] ld, input logic mis);
        checks++;
        if (mem_wdata !== wd || mem_be !== be || load_data !== ld || misalign !== mis) begin
            errors++;
            $display("FAIL %s: got wd=%h be=%b ld=%h mis=%b, expected wd=%h be=%b ld=%h mis=%b",
                     tag, mem_wdata, mem_be, load_data, misalign, wd, be, ld, mis);
        end
    endtask

    // Drive at a falling edge, probe before the rising edge (R2), compare at the next falling edge.
    task automatic apply(input logic [3:0] o, input logic [1:0] a,
                         input logic [31:0] s, input logic [31:0] r);
        logic [31:0] p_wd, p_ld;
        logic [3:0]  p_be;
        logic        p_mis;
        p_wd = e_wd; p_ld = e_ld; p_be = e_be; p_mis = e_mis;
        op = o; off = a; sd = s; rd = r;
        #1;
        compare("R2", p_wd, p_be, p_ld, p_mis);
        model(o, a, s, r);
        @(negedge clk);
        compare(e_tag, e_wd, e_be, e_ld, e_mis);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rpat [2];
        rpat[0] = 32'h80FF7F01;
        rpat[1] = 32'h7F0180FF;
        // R1: reset holds every output at zero even with an active store presented.
        op = 4'h8; sd = 32'hDEADBEEF; rd = 32'hFFFFFFFF;
        repeat (3) begin
            @(negedge clk);
            compare("R1", '0, '0, '0, 1'b0);
        end
        op = 4'h0;
        @(negedge clk);
        rst_n = 1'b1;
        e_wd = '0; e_be = '0; e_ld = '0; e_mis = 0;
        @(negedge clk);
        // Every code at every offset (R3..R10).
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 16; c++)
                for (int a = 0; a < 4; a++)
                    apply(4'(c), 2'(a), 32'hA1B2C3D4 ^ {32{p[0]}}, rpat[p]);
        // Random traffic.
        for (int i = 0; i < 4000; i++)
            apply(4'($urandom), 2'($urandom), $urandom, $urandom);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule